// File: doc/BRIEF.md
# Grouped blind-phase clear sequencer

This block drives the digital side of a bank of row-driver channels. A serial token shifts through a channel selection register on each rising edge of the row clock. A rising gate strobe latches the current selection into per-channel gate latches, and a falling row clock releases them. In the normal phase each selected channel drives its gate, and its clear while the clear strobe is high.

For a blind (noisy) phase the channels are split into equal groups. Each group in turn holds the clear outputs of all its unselected channels on and masks the latched gate outputs. Only one group is blind at any time, which keeps the peak clear current low. A blind step is requested by a falling gate strobe while a qualifier is high. This combination never occurs in normal operation. The qualifier is the row clock when readout continues, or the clear strobe when readout stops, as chosen by `mode_stop`.

A request first raises the high-bias indication. The group register advances only at the next rising row clock, one sample period later. After the last group the register returns to empty and normal operation resumes.

Top module: `blind_clear_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, the selection register, the gate latches, the group register and the pending flag are zero. With all strobes low, every output is therefore zero.
- R2: On each rising edge of `ctl_clk`, seen at a `clk` edge, the selection register shifts up by one place: `ser_in` enters channel 0. `ser_out` always shows the selection bit of the highest channel.
- R3: A rising `str_gate` copies the selection register into the gate latches. Otherwise a falling `ctl_clk` clears all gate latches. The strobe wins when both occur at the same edge.
- R4: `gate_out[i]` = (selection bit i AND `str_gate`) OR (gate latch i AND NOT any group-enable bit).
- R5: Channel i belongs to group i / (N_CH/N_GRP), so channels 0..7 are group 0 by default. `clear_out[i]` is the inverse of gate latch i when its group-enable bit is set. Otherwise it is gate latch i AND `str_clr`.
- R6: A blind request is a falling `str_gate` while the qualifier is high. The qualifier is `ctl_clk` when `mode_stop`=0 and `str_clr` when `mode_stop`=1. A request sets the pending flag. `bias_boost` is high whenever the pending flag or any group-enable bit is set.
- R7: A rising `ctl_clk` while the pending flag is set advances `noisy_en`: from 0 to group 0 (value 1), otherwise one place left. From the last group it returns to 0. The same edge clears the pending flag unless a new request arrives at that edge.
- R8: At most one bit of `noisy_en` is ever set.
- R9: A falling `str_gate` while the selected qualifier is low has no effect on `bias_boost` or `noisy_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_clk | input | 1 | Row clock level |
| ser_in | input | 1 | Serial selection token input |
| str_gate | input | 1 | Gate strobe |
| str_clr | input | 1 | Clear strobe |
| mode_stop | input | 1 | 1: request qualified by clear strobe (readout stops); 0: by row clock |
| ser_out | output | 1 | Selection bit of the last channel, for chaining |
| gate_out | output | N_CH | Per-channel gate drive |
| clear_out | output | N_CH | Per-channel clear drive |
| noisy_en | output | N_GRP | One-hot-or-zero group blind enable |
| bias_boost | output | 1 | High-bias request for the driver stage |

## Verification
The bench builds the block with its defaults of 32 channels in 4 groups of 8. With this setting a full walk through all groups and back to zero takes only a handful of requests. Random strobe patterns therefore cover wrap-around, group boundaries at channels 7/8 and 31, and requests that arrive while one is still pending. Both qualifier modes are run, together with directed cases for the one-period delay and for rejected requests.

// File: rtl/blind_clear_seq.sv
module blind_clear_seq #(
  parameter int N_CH  = 32,
  parameter int N_GRP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_clk,
  input  logic             ser_in,
  input  logic             str_gate,
  input  logic             str_clr,
  input  logic             mode_stop,
  output logic             ser_out,
  output logic [N_CH-1:0]  gate_out,
  output logic [N_CH-1:0]  clear_out,
  output logic [N_GRP-1:0] noisy_en,
  output logic             bias_boost
);
  localparam int GRP_W = N_CH / N_GRP;

  logic            ctl_q, gate_q, pend;
  logic [N_CH-1:0] sel, a_lat, noisy_ch;

  wire clk_rise  = ctl_clk & ~ctl_q;
  wire clk_fall  = ~ctl_clk & ctl_q;
  wire strb_rise = str_gate & ~gate_q;
  wire strb_fall = ~str_gate & gate_q;
  wire qual      = mode_stop ? str_clr : ctl_clk;
  wire request   = strb_fall & qual;
  wire any_noisy = |noisy_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= 1'b0;
      gate_q   <= 1'b0;
      sel      <= '0;
      a_lat    <= '0;
      noisy_en <= '0;
      pend     <= 1'b0;
    end else begin
      ctl_q  <= ctl_clk;
      gate_q <= str_gate;
      if (clk_rise) sel <= {sel[N_CH-2:0], ser_in};
      if (strb_rise)      a_lat <= sel;
      else if (clk_fall)  a_lat <= '0;
      if (clk_rise && pend)
        noisy_en <= any_noisy ? (noisy_en << 1) : N_GRP'(1);
      if (request)       pend <= 1'b1;
      else if (clk_rise) pend <= 1'b0;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign noisy_ch[i]  = noisy_en[i / GRP_W];
    assign clear_out[i] = noisy_ch[i] ? ~a_lat[i] : (a_lat[i] & str_clr);
  end

  assign gate_out   = (sel & {N_CH{str_gate}}) | (a_lat & {N_CH{~any_noisy}});
  assign ser_out    = sel[N_CH-1];
  assign bias_boost = pend | any_noisy;
endmodule

// File: rtl/blind_clear_seq_chk.sv
module blind_clear_seq_chk #(
  parameter int N_CH  = 32,
  parameter int N_GRP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             str_gate,
  input logic             str_clr,
  input logic [N_CH-1:0]  gate_out,
  input logic [N_CH-1:0]  clear_out,
  input logic [N_GRP-1:0] noisy_en,
  input logic             bias_boost
);
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(noisy_en));

  p_boost_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|noisy_en) |-> bias_boost);

  p_idle_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_boost |=> (noisy_en == '0));

  p_gate_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|noisy_en) && !str_gate) |-> (gate_out == '0));

  p_clear_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!str_clr && noisy_en == '0) |-> (clear_out == '0));
endmodule

bind blind_clear_seq blind_clear_seq_chk #(.N_CH(N_CH), .N_GRP(N_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .str_gate(str_gate), .str_clr(str_clr),
  .gate_out(gate_out), .clear_out(clear_out), .noisy_en(noisy_en),
  .bias_boost(bias_boost));

// File: tb/blind_clear_seq_tb.sv
module blind_clear_seq_tb;
  localparam int N_CH = 32, N_GRP = 4, GRP_W = N_CH / N_GRP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_clk = 0, ser_in = 0, str_gate = 0, str_clr = 0, mode_stop = 0;
  logic ser_out, bias_boost;
  logic [N_CH-1:0] gate_out, clear_out;
  logic [N_GRP-1:0] noisy_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [N_CH-1:0] m_sel = '0, m_a = '0;
  logic [N_GRP-1:0] m_noisy = '0;
  logic m_pend = 0, m_pclk = 0, m_pgate = 0;

  always #2 clk = ~clk;

  blind_clear_seq #(.N_CH(N_CH), .N_GRP(N_GRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ser_in(ser_in),
    .str_gate(str_gate), .str_clr(str_clr), .mode_stop(mode_stop),
    .ser_out(ser_out), .gate_out(gate_out), .clear_out(clear_out),
    .noisy_en(noisy_en), .bias_boost(bias_boost));

  function automatic logic [N_CH-1:0] exp_gate();
    logic [N_CH-1:0] r;
    for (int i = 0; i < N_CH; i++)
      r[i] = (m_sel[i] & str_gate) | (m_a[i] & (m_noisy == '0));
    return r;
  endfunction

  function automatic logic [N_CH-1:0] exp_clr();
    logic [N_CH-1:0] r;
    for (int i = 0; i < N_CH; i++)
      r[i] = m_noisy[i / GRP_W] ? ~m_a[i] : (m_a[i] & str_clr);
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 ser_out", 64'(ser_out), 64'(m_sel[N_CH-1]));
    chk("R4 gate_out", 64'(gate_out), 64'(exp_gate()));
    chk("R5 clear_out", 64'(clear_out), 64'(exp_clr()));
    chk("R7 noisy_en", 64'(noisy_en), 64'(m_noisy));
    chk("R6 bias_boost", 64'(bias_boost), 64'(m_pend | (m_noisy != '0)));
    chk("R8 onehot0", 64'($countones(noisy_en) <= 1), 64'(1));
  endtask

  task automatic model_step();
    logic cr, cf, gr, gf, q, rq;
    cr = ctl_clk & ~m_pclk;  cf = ~ctl_clk & m_pclk;
    gr = str_gate & ~m_pgate; gf = ~str_gate & m_pgate;
    q  = mode_stop ? str_clr : ctl_clk;
    rq = gf & q;
    if (gr) m_a = m_sel; else if (cf) m_a = '0;
    if (cr && m_pend) m_noisy = (m_noisy == '0) ? N_GRP'(1) : (m_noisy << 1);
    if (rq) m_pend = 1; else if (cr) m_pend = 0;
    if (cr) m_sel = {m_sel[N_CH-2:0], ser_in};
    m_pclk = ctl_clk; m_pgate = str_gate;
  endtask

  task automatic cyc(logic c, logic s, logic g, logic r, logic m);
    @(negedge clk);
    ctl_clk = c; ser_in = s; str_gate = g; str_clr = r; mode_stop = m;
    #1 check_all();
    @(posedge clk);
    model_step();
  endtask

  task automatic request_and_step(logic m);
    cyc(1, 0, 0, m, m);
    cyc(1, 0, 1, m, m);
    cyc(1, 0, 0, m, m);
    @(negedge clk); #1;
    chk("R6 boost after request", 64'(bias_boost), 64'(1));
    chk("R6 no advance before clock", 64'(noisy_en), 64'(m_noisy));
    cyc(0, 0, 0, 0, m);
    cyc(1, 0, 0, 0, m);
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset gate", 64'(gate_out), 64'(0));
    chk("R1 reset clear", 64'(clear_out), 64'(0));
    chk("R1 reset noisy", 64'(noisy_en), 64'(0));
    chk("R1 reset boost", 64'(bias_boost), 64'(0));
    rst_n = 1;

    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R3 latched gate ch0", 64'(gate_out[0]), 64'(1));
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R3 falling clock releases", 64'(gate_out), 64'(0));

    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(1, 0, 1, 0, 1);
    cyc(1, 0, 0, 0, 1);
    @(negedge clk); #1;
    chk("R9 unqualified falling strobe ignored", 64'(bias_boost), 64'(0));
    chk("R9 noisy unchanged", 64'(noisy_en), 64'(0));

    for (int k = 0; k < N_GRP + 1; k++) begin
      request_and_step(k[0]);
      @(negedge clk); #1;
      chk("R7 group walk", 64'(noisy_en),
          64'((k < N_GRP) ? (1 << k) : 0));
    end

    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 4000; n++)
        cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'(ph[0]));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule